// File: doc/BRIEF.md
# Fault-Aware Set-Associative Cache Tag Unit

This unit holds the tag state of a set-associative cache in which any block with a permanently faulty cell is switched off. Each way of each set carries a valid bit, a dirty bit and a disable bit. A lookup compares the address tag against the enabled ways of the addressed set and reports hit or miss, together with the way that serves the access. On a miss a victim is chosen among the enabled ways, and the refill is recorded in the same cycle. Empty enabled ways are filled first, and after that the least recently used enabled way is replaced. A set that has lost f of its n ways therefore acts as an (n-f)-way LRU set, whichever physical ways have failed.

Disable bits are written through a separate port at boot or test time. Switching a way off drops its contents, and a one-cycle pulse reports that modified data was lost when the way held a dirty line. A set whose ways are all switched off can hold nothing. It is flagged in a per-set vector, and a single summary flag tells that the cache as a whole is unusable. Data storage, error-code generation and fault detection are outside this unit.

Top module: `bdc_tag_unit`

## Requirements
- R1: After reset every way is empty, dirty-free and enabled, `dead_sets` and `cache_unusable` are 0, and all response outputs are 0.
- R2: When a request (`req_valid`=1, `dis_we`=0) matches the stored tag of a valid enabled way, `resp_hit`=1 and `resp_way` gives that way index on the cycle after the request. `resp_hit` and `resp_miss` are never both 1, and both are 0 after a cycle with no request.
- R3: On a miss, `resp_miss`=1 and the line is allocated in the lowest-numbered enabled empty way if one exists, and `resp_way` reports that way. The address is split as offset (low log2(LINE_BYTES) bits), then set index (log2(SETS) bits), then tag (the remaining high bits).
- R4: A hit or a fill makes the way most recently used. When every enabled way is valid, a miss replaces the least recently used enabled way.
- R5: A disabled way never produces a hit, even when its old tag matches, and it is never chosen as a victim.
- R6: Writing disable value 1 to a way clears its valid and dirty bits. `dis_wb`=1 on the next cycle exactly when that way was valid and dirty.
- R7: A request with `req_write`=1 marks the hit or filled way dirty. A miss that replaces a valid dirty way raises `resp_wb` together with `resp_miss`.
- R8: Bit s of `dead_sets` is 1 exactly when every way of set s is disabled, and `cache_unusable` is the OR of all bits. A lookup into such a set gives `resp_miss`=1, `resp_dead`=1, `resp_wb`=0 and allocates nothing.
- R9: A disable write takes priority over a request in the same cycle. That request is dropped with no response and no change to the tag state.
- R10: Writing disable value 0 re-enables a way as empty, so it is the first fill candidate for the next miss in its set, provided it is the lowest-numbered empty enabled way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Request is a store (marks line dirty) |
| dis_we | input | 1 | Disable-bit write strobe |
| dis_set | input | log2(SETS) | Set addressed by the disable write |
| dis_way | input | log2(WAYS) | Way addressed by the disable write |
| dis_val | input | 1 | New disable bit value |
| resp_hit | output | 1 | Previous request hit |
| resp_miss | output | 1 | Previous request missed |
| resp_way | output | log2(WAYS) | Way hit or filled |
| resp_wb | output | 1 | Miss replaced a dirty line |
| resp_dead | output | 1 | Miss fell into a fully disabled set |
| dis_wb | output | 1 | Disabled way held dirty data |
| dead_sets | output | SETS | Per-set all-ways-disabled flags |
| cache_unusable | output | 1 | Some set has no usable way |

## Verification
The hardest situation to reach from the ports is a set with a mixture of disabled, re-enabled and fully occupied ways. In that state the recency order, the empty-way preference and the disable mask all affect the victim choice together. The random phase gets there by aiming accesses at only four sets with a small tag pool, which fills the sets and forces evictions. It interleaves occasional disable writes that set and clear bits, so sets regularly shrink, die and come back. Directed steps first build the exact cases: a dirty way is disabled, a stale tag sits in a disabled way, a whole set is killed and then revived, and a disable write collides with a request.

// File: rtl/bdc_pkg.sv
`timescale 1ns/1ps
package bdc_pkg;
   // Outcome of one cycle's lookup
   typedef enum logic [1:0] {
      K_IDLE = 2'd0,
      K_HIT  = 2'd1,
      K_FILL = 2'd2,
      K_DEAD = 2'd3
   } lookup_kind_e;
endpackage

// File: rtl/bdc_tag_match.sv
`timescale 1ns/1ps
module bdc_tag_match #(
   parameter int WAYS  = 8,
   parameter int TAG_W = 28
) (
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]      tag,
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS-1:0]       disabled,
   output logic [WAYS-1:0]       hit_vec
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit_vec[w] = valid[w] & ~disabled[w] & (tags[w*TAG_W +: TAG_W] == tag);
   end
endmodule

// File: rtl/bdc_victim_pick.sv
`timescale 1ns/1ps
module bdc_victim_pick #(
   parameter int WAYS  = 8,
   parameter int WAY_W = 3
) (
   input  logic [WAYS-1:0]       usable,
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS*WAY_W-1:0] order,   // slot 0 = most recent
   output logic [WAY_W-1:0]      victim,
   output logic                  found
);
   logic [WAY_W-1:0] w;
   always_comb begin
      victim = '0;
      found  = 1'b0;
      w      = '0;
      // walk from recent to old: the last usable way seen is the oldest
      for (int p = 0; p < WAYS; p++) begin
         w = order[p*WAY_W +: WAY_W];
         if (usable[w]) begin
            victim = w;
            found  = 1'b1;
         end
      end
      // an empty usable way wins; lowest index last so it has priority
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (usable[i] && !valid[i]) victim = WAY_W'(i);
      end
   end
endmodule

// File: rtl/bdc_lru_touch.sv
`timescale 1ns/1ps
module bdc_lru_touch #(
   parameter int WAYS  = 8,
   parameter int WAY_W = 3
) (
   input  logic [WAYS*WAY_W-1:0] order_in,
   input  logic [WAY_W-1:0]      way,
   output logic [WAYS*WAY_W-1:0] order_out
);
   int k;
   always_comb begin
      order_out = '0;
      order_out[0 +: WAY_W] = way;
      k = 1;
      for (int p = 0; p < WAYS; p++) begin
         if (order_in[p*WAY_W +: WAY_W] != way) begin
            if (k < WAYS) order_out[k*WAY_W +: WAY_W] = order_in[p*WAY_W +: WAY_W];
            k = k + 1;
         end
      end
   end
endmodule

// File: rtl/bdc_tag_unit.sv
`timescale 1ns/1ps
module bdc_tag_unit
   import bdc_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int SETS       = 64,
   parameter int WAYS       = 8,
   parameter int LINE_BYTES = 64,
   localparam int IDX_W     = $clog2(SETS),
   localparam int WAY_W     = $clog2(WAYS),
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              dis_we,
   input  logic [IDX_W-1:0]  dis_set,
   input  logic [WAY_W-1:0]  dis_way,
   input  logic              dis_val,
   output logic              resp_hit,
   output logic              resp_miss,
   output logic [WAY_W-1:0]  resp_way,
   output logic              resp_wb,
   output logic              resp_dead,
   output logic              dis_wb,
   output logic [SETS-1:0]   dead_sets,
   output logic              cache_unusable
);
   // elaboration-time parameter checks
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for SETS and LINE_BYTES");
   end

   // state
   logic [TAG_W-1:0]        tag_q   [SETS][WAYS];
   logic [WAYS-1:0]         val_q   [SETS];
   logic [WAYS-1:0]         dirty_q [SETS];
   logic [WAYS-1:0]         dis_q   [SETS];
   logic [WAYS*WAY_W-1:0]   ord_q   [SETS];

   // address split
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] rtag;
   assign idx  = req_addr[OFF_W +: IDX_W];
   assign rtag = req_addr[ADDR_W-1 -: TAG_W];

   logic [WAYS*TAG_W-1:0] set_tags;
   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign set_tags[w*TAG_W +: TAG_W] = tag_q[idx][w];
   end

   logic [WAYS-1:0] hit_vec;
   bdc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .tags(set_tags), .tag(rtag), .valid(val_q[idx]),
      .disabled(dis_q[idx]), .hit_vec(hit_vec)
   );

   logic [WAY_W-1:0] victim;
   logic             vic_found;
   bdc_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
      .usable(~dis_q[idx]), .valid(val_q[idx]), .order(ord_q[idx]),
      .victim(victim), .found(vic_found)
   );

   logic [WAY_W-1:0] hit_idx;
   always_comb begin
      hit_idx = '0;
      for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_idx = WAY_W'(w);
   end

   lookup_kind_e kind;
   always_comb begin
      kind = K_IDLE;
      if (req_valid && !dis_we) begin
         if (|hit_vec)       kind = K_HIT;
         else if (vic_found) kind = K_FILL;
         else                kind = K_DEAD;
      end
   end

   logic [WAY_W-1:0]      use_way;
   logic [WAYS*WAY_W-1:0] ord_next;
   assign use_way = (kind == K_HIT) ? hit_idx : victim;
   bdc_lru_touch #(.WAYS(WAYS), .WAY_W(WAY_W)) u_touch (
      .order_in(ord_q[idx]), .way(use_way), .order_out(ord_next)
   );

   // tag array: no reset, written only on fill
   always_ff @(posedge clk) begin
      if (kind == K_FILL) tag_q[idx][victim] <= rtag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            val_q[s]   <= '0;
            dirty_q[s] <= '0;
            dis_q[s]   <= '0;
            for (int w = 0; w < WAYS; w++) ord_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
         end
         resp_hit  <= 1'b0;
         resp_miss <= 1'b0;
         resp_way  <= '0;
         resp_wb   <= 1'b0;
         resp_dead <= 1'b0;
         dis_wb    <= 1'b0;
      end else begin
         resp_hit  <= 1'b0;
         resp_miss <= 1'b0;
         resp_way  <= '0;
         resp_wb   <= 1'b0;
         resp_dead <= 1'b0;
         dis_wb    <= 1'b0;
         if (dis_we) begin
            dis_q[dis_set][dis_way] <= dis_val;
            if (dis_val) begin
               val_q[dis_set][dis_way]   <= 1'b0;
               dirty_q[dis_set][dis_way] <= 1'b0;
               dis_wb <= val_q[dis_set][dis_way] & dirty_q[dis_set][dis_way];
            end
         end else begin
            case (kind)
               K_HIT: begin
                  resp_hit   <= 1'b1;
                  resp_way   <= hit_idx;
                  ord_q[idx] <= ord_next;
                  if (req_write) dirty_q[idx][hit_idx] <= 1'b1;
               end
               K_FILL: begin
                  resp_miss  <= 1'b1;
                  resp_way   <= victim;
                  resp_wb    <= val_q[idx][victim] & dirty_q[idx][victim];
                  ord_q[idx] <= ord_next;
                  val_q[idx][victim]   <= 1'b1;
                  dirty_q[idx][victim] <= req_write;
               end
               K_DEAD: begin
                  resp_miss <= 1'b1;
                  resp_dead <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   for (genvar s = 0; s < SETS; s++) begin : g_dead
      assign dead_sets[s] = &dis_q[s];
   end
   assign cache_unusable = |dead_sets;
endmodule

// File: rtl/bdc_tag_unit_chk.sv
`timescale 1ns/1ps
module bdc_tag_unit_chk #(
   parameter int ADDR_W     = 40,
   parameter int SETS       = 64,
   parameter int WAYS       = 8,
   parameter int LINE_BYTES = 64,
   localparam int IDX_W     = $clog2(SETS),
   localparam int WAY_W     = $clog2(WAYS),
   localparam int OFF_W     = $clog2(LINE_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              dis_we,
   input logic              dis_val,
   input logic              resp_hit,
   input logic              resp_miss,
   input logic              resp_wb,
   input logic              resp_dead,
   input logic              dis_wb,
   input logic [SETS-1:0]   dead_sets,
   input logic              cache_unusable
);
   logic [IDX_W-1:0] ridx;
   assign ridx = req_addr[OFF_W +: IDX_W];

   p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(resp_hit && resp_miss));
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(resp_hit || resp_miss));
   p_wb_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_wb |-> resp_miss);
   p_dead_is_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_dead |-> (resp_miss && !resp_wb));
   p_dead_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !dis_we && dead_sets[ridx]) |=> (resp_miss && resp_dead));
   p_unusable_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cache_unusable) |-> $past(dis_we && dis_val));
   p_disable_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dis_we |=> !(resp_hit || resp_miss));
   p_dis_wb_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_wb |-> $past(dis_we && dis_val));
endmodule

bind bdc_tag_unit bdc_tag_unit_chk #(
   .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/tb_bdc_tag_unit.sv
`timescale 1ns/1ps
module tb_bdc_tag_unit;
   localparam int ADDR_W = 40, SETS = 64, WAYS = 8, LINE_BYTES = 64;
   localparam int IDX_W = $clog2(SETS), WAY_W = $clog2(WAYS), OFF_W = $clog2(LINE_BYTES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n, req_valid, req_write, dis_we, dis_val;
   logic [ADDR_W-1:0] req_addr;
   logic [IDX_W-1:0]  dis_set;
   logic [WAY_W-1:0]  dis_way;
   logic              resp_hit, resp_miss, resp_wb, resp_dead, dis_wb, cache_unusable;
   logic [WAY_W-1:0]  resp_way;
   logic [SETS-1:0]   dead_sets;

   bdc_tag_unit #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .dis_we(dis_we), .dis_set(dis_set), .dis_way(dis_way),
      .dis_val(dis_val), .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_way(resp_way),
      .resp_wb(resp_wb), .resp_dead(resp_dead), .dis_wb(dis_wb),
      .dead_sets(dead_sets), .cache_unusable(cache_unusable)
   );

   int checks = 0, failures = 0;
   bit done = 0;

   // reference model
   bit               m_val   [SETS][WAYS];
   bit               m_dirty [SETS][WAYS];
   bit               m_dis   [SETS][WAYS];
   logic [TAG_W-1:0] m_tag   [SETS][WAYS];
   int               m_stamp [SETS][WAYS];
   int               now = 0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [SETS-1:0] exp_dead();
      logic [SETS-1:0] d;
      for (int s = 0; s < SETS; s++) begin
         d[s] = 1'b1;
         for (int w = 0; w < WAYS; w++) if (!m_dis[s][w]) d[s] = 1'b0;
      end
      return d;
   endfunction

   task automatic model_req(input int s, input logic [TAG_W-1:0] t, input bit wr,
                            output bit eh, output bit em, output bit ewb, output bit edead, output int ew);
      int v, best;
      eh = 0; em = 0; ewb = 0; edead = 0; ew = 0; v = -1; best = 32'h7fffffff;
      for (int w = 0; w < WAYS; w++)
         if (!m_dis[s][w] && m_val[s][w] && m_tag[s][w] == t) begin eh = 1; ew = w; end
      now++;
      if (eh) begin
         m_stamp[s][ew] = now;
         if (wr) m_dirty[s][ew] = 1;
      end else begin
         em = 1;
         for (int w = 0; w < WAYS; w++) if (v < 0 && !m_dis[s][w] && !m_val[s][w]) v = w;
         if (v < 0)
            for (int w = 0; w < WAYS; w++)
               if (!m_dis[s][w] && m_stamp[s][w] < best) begin best = m_stamp[s][w]; v = w; end
         if (v < 0) edead = 1;
         else begin
            ew = v; ewb = m_val[s][v] && m_dirty[s][v];
            m_val[s][v] = 1; m_tag[s][v] = t; m_dirty[s][v] = wr; m_stamp[s][v] = now;
         end
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic do_req(input int s, input logic [TAG_W-1:0] t, input bit wr, input string req);
      bit eh, em, ewb, edead; int ew;
      req_valid = 1; req_write = wr;
      req_addr = {t, IDX_W'(s), OFF_W'($urandom)};
      model_req(s, t, wr, eh, em, ewb, edead, ew);
      @(negedge clk);
      chk(req, "hit", resp_hit, eh);
      chk(req, "miss", resp_miss, em);
      chk(req, "dead", resp_dead, edead);
      chk(req, "wb", resp_wb, ewb);
      if (!edead) chk(req, "way", resp_way, ew);
      req_valid = 0; req_write = 0;
   endtask

   task automatic do_dis(input int s, input int w, input bit v, input bit with_req, input string req);
      bit ewb;
      logic [SETS-1:0] ed;
      dis_we = 1; dis_set = IDX_W'(s); dis_way = WAY_W'(w); dis_val = v;
      if (with_req) begin
         req_valid = 1; req_write = 1; req_addr = {TAG_W'(77), IDX_W'(s), OFF_W'(0)};
      end
      ewb = v && m_val[s][w] && m_dirty[s][w];
      m_dis[s][w] = v;
      if (v) begin m_val[s][w] = 0; m_dirty[s][w] = 0; end
      ed = exp_dead();
      @(negedge clk);
      chk(req, "dis_wb", dis_wb, ewb);
      chk(req, "dead_sets", dead_sets, ed);
      chk(req, "unusable", cache_unusable, |ed);
      if (with_req) begin
         chk(req, "dropped_hit", resp_hit, 0);
         chk(req, "dropped_miss", resp_miss, 0);
      end
      dis_we = 0; req_valid = 0; req_write = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0;
      dis_we = 0; dis_set = '0; dis_way = '0; dis_val = 0;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_val[s][w] = 0; m_dirty[s][w] = 0; m_dis[s][w] = 0; m_tag[s][w] = '0; m_stamp[s][w] = 0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "hit", resp_hit, 0);
      chk("R1", "miss", resp_miss, 0);
      chk("R1", "dead_sets", dead_sets, 0);
      chk("R1", "unusable", cache_unusable, 0);
      chk("R1", "dis_wb", dis_wb, 0);
      do_req(5, 100, 0, "R1");                        // first fill goes to way 0
      for (int i = 1; i < WAYS; i++) do_req(5, TAG_W'(100 + i), 0, "R3");
      do_req(5, 103, 0, "R2");                        // hit way 3
      do_req(5, 200, 0, "R4");                        // evicts way 0
      do_req(5, 201, 0, "R4");                        // evicts way 1
      // R7: dirty eviction in set 6
      do_req(6, 1, 1, "R7");
      for (int i = 2; i <= WAYS; i++) do_req(6, TAG_W'(i), 0, "R7");
      do_req(6, 50, 0, "R7");                         // replaces dirty way 0
      // R6: disable a dirty way
      do_req(5, 105, 1, "R6");
      do_dis(5, 5, 1, 0, "R6");
      do_req(5, 105, 0, "R5");                        // old tag does not hit
      // R5: stale tag in disabled way, set 9
      do_req(9, 7, 0, "R5");
      do_dis(9, 0, 1, 0, "R5");
      do_req(9, 7, 0, "R5");                          // lands in way 1
      // R8: kill set 7
      do_req(7, 3, 1, "R8");
      for (int w = 0; w < WAYS; w++) do_dis(7, w, 1, 0, "R8");
      do_req(7, 3, 0, "R8");
      // R10: revive way 3 of set 7
      do_dis(7, 3, 0, 0, "R10");
      do_req(7, 9, 0, "R10");
      // R9: collision of disable write and request
      do_dis(12, 2, 1, 1, "R9");
      do_req(12, 77, 0, "R9");                        // dropped request allocated nothing
      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 99) < 5)
            do_dis($urandom_range(0, 3), $urandom_range(0, WAYS - 1), $urandom_range(0, 1), 0, "R6");
         else
            do_req($urandom_range(0, 3), TAG_W'($urandom_range(0, 11)), $urandom_range(0, 1), "R4");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule